// File: doc/BRIEF.md
# Store Buffer with Retired-Store Drain Queue

This block holds store operations between dispatch and the data cache. Each store takes a slot in program order when it is dispatched. It becomes complete once both its address and its data have arrived, in either order. It is retired when the commit stage asks for it and it is the oldest slot. A retired store leaves the store buffer at once and moves into a separate drain queue. The drain queue writes its contents to the cache write port with no further commands.

Loads present an address and get forwarded data from whichever queue holds the newest copy. A branch flush throws away every store that has not yet retired. Stores already in the drain queue are architectural state and always reach the cache.

Each store-buffer slot is a small state machine:
- SLOT_EMPTY moves to SLOT_WAIT on *allocate*.
- SLOT_WAIT moves to SLOT_DONE on *complete*, which needs both address and data.
- SLOT_DONE moves to SLOT_EMPTY on *retire*.
- Any occupied slot moves to SLOT_EMPTY on *flush*.

Each drain-queue slot has its own state machine:
- WB_FREE moves to WB_LIVE on *enter*.
- WB_LIVE moves to WB_DEAD on *supersede*, when a newer store to the same address enters.
- WB_LIVE moves to WB_FREE on *write*, a cache handshake.
- WB_DEAD moves to WB_FREE on *skip*.

Top module: `store_wb_buffer`

## Requirements
- R1: After reset, `disp_ready`=1, `disp_tag`=0, `commit_ok`=0, `ld_hit`=0 and `cw_valid`=0.
- R2: Accepted dispatches receive tags 0,1,2,... in order, wrapping modulo SB_DEPTH. A newly allocated store is not complete, so `commit_ok` stays 0 while it is the oldest.
- R3: A store becomes complete only when both its address and its data have been supplied, in either order. `commit_ok` rises in the cycle after the second one is accepted when that store is the oldest.
- R4: With SB_DEPTH stores held, `disp_ready`=0. A dispatch attempt then changes nothing, and `disp_tag` keeps its value.
- R5: `commit_req` while `commit_ok`=1 moves the oldest store into the drain queue. If the drain queue was empty, `cw_valid`=1 with that store's address and data in the next cycle.
- R6: `commit_req` while the oldest store is incomplete is ignored. The store stays in the buffer and retires normally later.
- R7: The drain queue writes live entries in retirement order, one per handshake (`cw_valid` and `cw_ready`). While `cw_ready`=0 the offered address and data hold steady.
- R8: When a store enters the drain queue, older live entries with the same address are superseded and never written. The entry currently offered on the cache port is the one exception and completes its write.
- R9: A load lookup returns the youngest complete matching store-buffer entry (`ld_src`=0). Failing that, it returns the youngest live matching drain-queue entry (`ld_src`=1). Otherwise `ld_hit`=0.
- R10: `flush` empties the store buffer. Afterwards lookups no longer hit flushed stores, `commit_ok`=0, `disp_ready`=1 and `disp_tag` equals the oldest unretired slot index. Drain-queue contents are untouched.
- R11: `commit_ok` is 0 while the drain queue has no free slot, including slots held by superseded entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch a new store |
| disp_ready | output | 1 | A slot is free and no flush is active |
| disp_tag | output | log2(SB_DEPTH) | Slot index the next dispatched store receives |
| agen_valid | input | 1 | Address delivery for a store |
| agen_tag | input | log2(SB_DEPTH) | Slot addressed by agen |
| agen_addr | input | ADDR_W | Store address |
| data_valid | input | 1 | Data delivery for a store |
| data_tag | input | log2(SB_DEPTH) | Slot addressed by data delivery |
| data_val | input | DATA_W | Store data |
| commit_req | input | 1 | Commit asks to retire the oldest store |
| commit_ok | output | 1 | Oldest store is complete and the drain queue has room |
| flush | input | 1 | Discard all unretired stores |
| ld_addr | input | ADDR_W | Load lookup address |
| ld_hit | output | 1 | Forwarded data available |
| ld_src | output | 1 | 0 = store buffer, 1 = drain queue |
| ld_data | output | DATA_W | Forwarded data |
| cw_valid | output | 1 | Cache write request |
| cw_ready | input | 1 | Cache accepts the write |
| cw_addr | output | ADDR_W | Cache write address |
| cw_data | output | DATA_W | Cache write data |

## Verification
Lookup results and `disp_ready` are combinational on the current state, so the bench checks them in the same cycle as the inputs, at the falling edge. An allocate, complete, retire or flush is registered at the next rising edge, and its effect on `commit_ok`, `disp_tag` and `cw_valid` is sampled at the falling edge that follows. A retired store therefore appears on the cache port one cycle after the `commit_req` edge. A scoreboard queue receives each expected cache write when the bench retires a store. The queue leaves out superseded stores. A monitor pops and compares an entry at every falling edge where `cw_valid` and `cw_ready` are both high, so each handshake is judged in its own cycle.

// File: rtl/sbwb_pkg.sv
package sbwb_pkg;
    typedef enum logic [1:0] {SLOT_EMPTY, SLOT_WAIT, SLOT_DONE} sb_state_e;
    typedef enum logic [1:0] {WB_FREE, WB_LIVE, WB_DEAD} wb_state_e;
endpackage

// File: rtl/sb_queue.sv
module sb_queue
    import sbwb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_valid,
    output logic          alloc_ready,
    output logic [IW-1:0] alloc_tag,
    input  logic          agen_valid,
    input  logic [IW-1:0] agen_tag,
    input  logic [AW-1:0] agen_addr,
    input  logic          data_valid,
    input  logic [IW-1:0] data_tag,
    input  logic [DW-1:0] data_val,
    input  logic          retire,
    input  logic          flush,
    output logic          head_done,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic [IW-1:0] head_ptr,
    output logic [CW-1:0] used,
    output logic [AW-1:0] ent_addr [DEPTH],
    output logic [DW-1:0] ent_data [DEPTH],
    output logic          ent_done [DEPTH]
);
    sb_state_e     st_q [DEPTH];
    sb_state_e     st_d [DEPTH];
    logic          have_a [DEPTH];
    logic          have_d [DEPTH];
    logic [IW-1:0] head_q, tail_q;
    logic [CW-1:0] cnt_q;
    logic          alloc_fire;

    function automatic logic [IW-1:0] step_ptr(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign alloc_ready = (cnt_q != CW'(DEPTH)) && !flush;
    assign alloc_fire  = alloc_valid && alloc_ready;
    assign alloc_tag   = tail_q;
    assign head_ptr    = head_q;
    assign used        = cnt_q;

    // next-state logic of every slot
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            logic got_a, got_d;
            got_a = have_a[i] || (agen_valid && agen_tag == IW'(i));
            got_d = have_d[i] || (data_valid && data_tag == IW'(i));
            st_d[i] = st_q[i];
            unique case (st_q[i])
                SLOT_EMPTY: if (alloc_fire && tail_q == IW'(i)) st_d[i] = SLOT_WAIT;
                SLOT_WAIT:  if (got_a && got_d) st_d[i] = SLOT_DONE;
                SLOT_DONE:  if (retire && head_q == IW'(i)) st_d[i] = SLOT_EMPTY;
                default:    st_d[i] = SLOT_EMPTY;
            endcase
            if (flush) st_d[i] = SLOT_EMPTY;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) st_q[i] <= SLOT_EMPTY;
            else        st_q[i] <= st_d[i];
        end
    end

    // payload and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                have_a[i]   <= 1'b0;
                have_d[i]   <= 1'b0;
                ent_addr[i] <= '0;
                ent_data[i] <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (st_q[i] == SLOT_EMPTY) begin
                    have_a[i] <= 1'b0;
                    have_d[i] <= 1'b0;
                end else if (st_q[i] == SLOT_WAIT) begin
                    if (agen_valid && agen_tag == IW'(i)) begin
                        have_a[i]   <= 1'b1;
                        ent_addr[i] <= agen_addr;
                    end
                    if (data_valid && data_tag == IW'(i)) begin
                        have_d[i]   <= 1'b1;
                        ent_data[i] <= data_val;
                    end
                end
            end
            if (retire) head_q <= step_ptr(head_q);
            if (flush) begin
                tail_q <= retire ? step_ptr(head_q) : head_q;
                cnt_q  <= '0;
            end else begin
                if (alloc_fire) tail_q <= step_ptr(tail_q);
                cnt_q <= cnt_q + CW'(alloc_fire) - CW'(retire);
            end
        end
    end

    // outputs
    always_comb begin
        for (int i = 0; i < DEPTH; i++) ent_done[i] = (st_q[i] == SLOT_DONE);
        head_done = (st_q[head_q] == SLOT_DONE);
        head_addr = ent_addr[head_q];
        head_data = ent_data[head_q];
    end
endmodule

// File: rtl/wb_queue.sv
module wb_queue
    import sbwb_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int AW    = 16,
    parameter int DW    = 32,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    output logic          has_room,
    output logic          cw_valid,
    input  logic          cw_ready,
    output logic [AW-1:0] cw_addr,
    output logic [DW-1:0] cw_data,
    output logic [IW-1:0] head_ptr,
    output logic [CW-1:0] used,
    output logic [AW-1:0] ent_addr [DEPTH],
    output logic [DW-1:0] ent_data [DEPTH],
    output logic          ent_live [DEPTH]
);
    wb_state_e     st_q [DEPTH];
    wb_state_e     st_d [DEPTH];
    logic [IW-1:0] head_q, tail_q;
    logic [CW-1:0] cnt_q;
    logic          pop;

    function automatic logic [IW-1:0] step_ptr(input logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign has_room = (cnt_q != CW'(DEPTH));
    assign pop      = (st_q[head_q] == WB_DEAD) ||
                      (st_q[head_q] == WB_LIVE && cw_ready);
    assign head_ptr = head_q;
    assign used     = cnt_q;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            logic supersede;
            supersede = push && ent_addr[i] == push_addr && head_q != IW'(i);
            st_d[i] = st_q[i];
            unique case (st_q[i])
                WB_FREE: if (push && tail_q == IW'(i)) st_d[i] = WB_LIVE;
                WB_LIVE: begin
                    if (pop && head_q == IW'(i)) st_d[i] = WB_FREE;
                    else if (supersede)          st_d[i] = WB_DEAD;
                end
                WB_DEAD: if (pop && head_q == IW'(i)) st_d[i] = WB_FREE;
                default: st_d[i] = WB_FREE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) st_q[i] <= WB_FREE;
            else        st_q[i] <= st_d[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                ent_addr[i] <= '0;
                ent_data[i] <= '0;
            end
        end else begin
            if (push) begin
                ent_addr[tail_q] <= push_addr;
                ent_data[tail_q] <= push_data;
                tail_q           <= step_ptr(tail_q);
            end
            if (pop) head_q <= step_ptr(head_q);
            cnt_q <= cnt_q + CW'(push) - CW'(pop);
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++) ent_live[i] = (st_q[i] == WB_LIVE);
        cw_valid = (st_q[head_q] == WB_LIVE);
        cw_addr  = ent_addr[head_q];
        cw_data  = ent_data[head_q];
    end
endmodule

// File: rtl/ld_forward.sv
module ld_forward #(
    parameter int SB_DEPTH = 4,
    parameter int WB_DEPTH = 4,
    parameter int AW       = 16,
    parameter int DW       = 32,
    localparam int SIW     = $clog2(SB_DEPTH),
    localparam int SCW     = $clog2(SB_DEPTH + 1),
    localparam int WIW     = $clog2(WB_DEPTH),
    localparam int WCW     = $clog2(WB_DEPTH + 1)
) (
    input  logic [AW-1:0]  ld_addr,
    input  logic [SIW-1:0] sb_head,
    input  logic [SCW-1:0] sb_used,
    input  logic [AW-1:0]  sb_addr [SB_DEPTH],
    input  logic [DW-1:0]  sb_data [SB_DEPTH],
    input  logic           sb_done [SB_DEPTH],
    input  logic [WIW-1:0] wb_head,
    input  logic [WCW-1:0] wb_used,
    input  logic [AW-1:0]  wb_addr [WB_DEPTH],
    input  logic [DW-1:0]  wb_data [WB_DEPTH],
    input  logic           wb_live [WB_DEPTH],
    output logic           hit,
    output logic           src,
    output logic [DW-1:0]  data
);
    logic          sb_hit, wb_hit;
    logic [DW-1:0] sb_val, wb_val;

    // walk oldest to youngest so the youngest match is kept
    always_comb begin
        sb_hit = 1'b0;
        sb_val = '0;
        for (int k = 0; k < SB_DEPTH; k++) begin
            int s;
            s = (int'(sb_head) + k) % SB_DEPTH;
            if (SCW'(k) < sb_used && sb_done[s] && sb_addr[s] == ld_addr) begin
                sb_hit = 1'b1;
                sb_val = sb_data[s];
            end
        end
        wb_hit = 1'b0;
        wb_val = '0;
        for (int k = 0; k < WB_DEPTH; k++) begin
            int s;
            s = (int'(wb_head) + k) % WB_DEPTH;
            if (WCW'(k) < wb_used && wb_live[s] && wb_addr[s] == ld_addr) begin
                wb_hit = 1'b1;
                wb_val = wb_data[s];
            end
        end
        hit  = sb_hit || wb_hit;
        src  = !sb_hit && wb_hit;
        data = sb_hit ? sb_val : wb_val;
    end
endmodule

// File: rtl/store_wb_buffer.sv
module store_wb_buffer #(
    parameter int SB_DEPTH = 4,
    parameter int WB_DEPTH = 4,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32,
    localparam int TW      = $clog2(SB_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    output logic              disp_ready,
    output logic [TW-1:0]     disp_tag,
    input  logic              agen_valid,
    input  logic [TW-1:0]     agen_tag,
    input  logic [ADDR_W-1:0] agen_addr,
    input  logic              data_valid,
    input  logic [TW-1:0]     data_tag,
    input  logic [DATA_W-1:0] data_val,
    input  logic              commit_req,
    output logic              commit_ok,
    input  logic              flush,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic              ld_hit,
    output logic              ld_src,
    output logic [DATA_W-1:0] ld_data,
    output logic              cw_valid,
    input  logic              cw_ready,
    output logic [ADDR_W-1:0] cw_addr,
    output logic [DATA_W-1:0] cw_data
);
    localparam int SCW = $clog2(SB_DEPTH + 1);
    localparam int WIW = $clog2(WB_DEPTH);
    localparam int WCW = $clog2(WB_DEPTH + 1);

    logic              head_done, wb_room, retire;
    logic [ADDR_W-1:0] head_addr;
    logic [DATA_W-1:0] head_data;
    logic [TW-1:0]     sb_head;
    logic [SCW-1:0]    sb_used;
    logic [ADDR_W-1:0] sb_addr [SB_DEPTH];
    logic [DATA_W-1:0] sb_data [SB_DEPTH];
    logic              sb_done [SB_DEPTH];
    logic [WIW-1:0]    wb_head;
    logic [WCW-1:0]    wb_used;
    logic [ADDR_W-1:0] wb_addr [WB_DEPTH];
    logic [DATA_W-1:0] wb_data [WB_DEPTH];
    logic              wb_live [WB_DEPTH];

    assign commit_ok = head_done && wb_room;
    assign retire    = commit_req && commit_ok;

    sb_queue #(.DEPTH(SB_DEPTH), .AW(ADDR_W), .DW(DATA_W)) u_sb (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(disp_valid), .alloc_ready(disp_ready), .alloc_tag(disp_tag),
        .agen_valid(agen_valid), .agen_tag(agen_tag), .agen_addr(agen_addr),
        .data_valid(data_valid), .data_tag(data_tag), .data_val(data_val),
        .retire(retire), .flush(flush),
        .head_done(head_done), .head_addr(head_addr), .head_data(head_data),
        .head_ptr(sb_head), .used(sb_used),
        .ent_addr(sb_addr), .ent_data(sb_data), .ent_done(sb_done)
    );

    wb_queue #(.DEPTH(WB_DEPTH), .AW(ADDR_W), .DW(DATA_W)) u_wb (
        .clk(clk), .rst_n(rst_n),
        .push(retire), .push_addr(head_addr), .push_data(head_data),
        .has_room(wb_room),
        .cw_valid(cw_valid), .cw_ready(cw_ready), .cw_addr(cw_addr), .cw_data(cw_data),
        .head_ptr(wb_head), .used(wb_used),
        .ent_addr(wb_addr), .ent_data(wb_data), .ent_live(wb_live)
    );

    ld_forward #(.SB_DEPTH(SB_DEPTH), .WB_DEPTH(WB_DEPTH), .AW(ADDR_W), .DW(DATA_W)) u_fwd (
        .ld_addr(ld_addr),
        .sb_head(sb_head), .sb_used(sb_used),
        .sb_addr(sb_addr), .sb_data(sb_data), .sb_done(sb_done),
        .wb_head(wb_head), .wb_used(wb_used),
        .wb_addr(wb_addr), .wb_data(wb_data), .wb_live(wb_live),
        .hit(ld_hit), .src(ld_src), .data(ld_data)
    );
endmodule

// File: rtl/store_wb_buffer_chk.sv
module store_wb_buffer_chk #(
    parameter int TW = 2,
    parameter int AW = 16,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          disp_valid,
    input logic          disp_ready,
    input logic [TW-1:0] disp_tag,
    input logic          commit_ok,
    input logic          flush,
    input logic          cw_valid,
    input logic          cw_ready,
    input logic [AW-1:0] cw_addr,
    input logic [DW-1:0] cw_data
);
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && !disp_ready && !flush) |=> $stable(disp_tag)); // R4

    AST_TAG_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid && disp_ready) |=> (disp_tag != $past(disp_tag))); // R2

    AST_CW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cw_valid && !cw_ready) |=> (cw_valid && $stable(cw_addr) && $stable(cw_data))); // R7

    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !commit_ok); // R10
endmodule

bind store_wb_buffer store_wb_buffer_chk #(.TW(TW), .AW(ADDR_W), .DW(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
    .disp_tag(disp_tag), .commit_ok(commit_ok), .flush(flush),
    .cw_valid(cw_valid), .cw_ready(cw_ready), .cw_addr(cw_addr), .cw_data(cw_data)
);

// File: tb/store_wb_buffer_tb.sv
module store_wb_buffer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          disp_valid = 1'b0, disp_ready;
    logic [1:0]    disp_tag;
    logic          agen_valid = 1'b0;
    logic [1:0]    agen_tag = '0;
    logic [AW-1:0] agen_addr = '0;
    logic          data_valid = 1'b0;
    logic [1:0]    data_tag = '0;
    logic [DW-1:0] data_val = '0;
    logic          commit_req = 1'b0, commit_ok, flush = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic          ld_hit, ld_src;
    logic [DW-1:0] ld_data;
    logic          cw_valid, cw_ready = 1'b0;
    logic [AW-1:0] cw_addr;
    logic [DW-1:0] cw_data;

    int total = 0;
    int bad = 0;
    int writes = 0;
    logic [AW+DW-1:0] exp_q [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    store_wb_buffer u_dut (
        .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
        .disp_tag(disp_tag), .agen_valid(agen_valid), .agen_tag(agen_tag),
        .agen_addr(agen_addr), .data_valid(data_valid), .data_tag(data_tag),
        .data_val(data_val), .commit_req(commit_req), .commit_ok(commit_ok),
        .flush(flush), .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_src(ld_src),
        .ld_data(ld_data), .cw_valid(cw_valid), .cw_ready(cw_ready),
        .cw_addr(cw_addr), .cw_data(cw_data)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic dispatch();
        disp_valid = 1'b1; tick(); disp_valid = 1'b0;
    endtask

    task automatic give_addr(input logic [1:0] t, input logic [AW-1:0] a);
        agen_valid = 1'b1; agen_tag = t; agen_addr = a; tick(); agen_valid = 1'b0;
    endtask

    task automatic give_data(input logic [1:0] t, input logic [DW-1:0] d);
        data_valid = 1'b1; data_tag = t; data_val = d; tick(); data_valid = 1'b0;
    endtask

    task automatic commit_pulse();
        commit_req = 1'b1; tick(); commit_req = 1'b0;
    endtask

    task automatic expect_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        exp_q.push_back({a, d});
    endtask

    // scoreboard monitor: every handshake is compared with the oldest expectation
    always @(negedge clk) begin
        if (rst_n && cw_valid && cw_ready) begin
            writes++;
            if (exp_q.size() == 0) begin
                chk("R7 unexpected write", longint'({cw_addr, cw_data}), 0);
            end else begin
                logic [AW+DW-1:0] e;
                e = exp_q.pop_front();
                chk("R7/R8 write order", longint'({cw_addr, cw_data}), longint'(e));
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        settle();
        chk("R1 disp_ready", disp_ready, 1);
        chk("R1 disp_tag", disp_tag, 0);
        chk("R1 commit_ok", commit_ok, 0);
        chk("R1 ld_hit", ld_hit, 0);
        chk("R1 cw_valid", cw_valid, 0);

        for (int i = 0; i < 4; i++) begin
            settle();
            chk("R2 tag order", disp_tag, i);
            dispatch();
        end
        settle();
        chk("R4 full ready", disp_ready, 0);
        chk("R2 new entry not complete", commit_ok, 0);
        dispatch();
        settle();
        chk("R4 refused tag", disp_tag, 0);
        chk("R4 still full", disp_ready, 0);

        give_addr(2'd0, 16'h0010);
        settle();
        chk("R3 address only", commit_ok, 0);
        give_data(2'd0, 32'hA0);
        settle();
        chk("R3 both present", commit_ok, 1);

        give_data(2'd1, 32'h11);
        give_addr(2'd1, 16'h0040);
        give_addr(2'd2, 16'h0040);
        give_data(2'd2, 32'h22);
        ld_addr = 16'h0040;
        settle();
        chk("R9 youngest sb hit", ld_hit, 1);
        chk("R9 youngest sb src", ld_src, 0);
        chk("R9 youngest sb data", ld_data, 32'h22);

        expect_write(16'h0010, 32'hA0);
        commit_pulse();
        settle();
        chk("R5 cw_valid", cw_valid, 1);
        chk("R5 cw_addr", cw_addr, 16'h0010);
        chk("R5 cw_data", cw_data, 32'hA0);

        commit_pulse();
        settle();
        chk("R9 sb over wb src", ld_src, 0);
        chk("R9 sb over wb data", ld_data, 32'h22);

        expect_write(16'h0040, 32'h22);
        commit_pulse();
        settle();
        chk("R6 head incomplete", commit_ok, 0);
        chk("R9 wb hit", ld_hit, 1);
        chk("R9 wb src", ld_src, 1);
        chk("R8 newest value", ld_data, 32'h22);

        commit_pulse();
        settle();
        chk("R6 commit ignored", commit_ok, 0);
        chk("R6 slot kept", disp_tag, 0);
        chk("R7 hold addr", cw_addr, 16'h0010);
        ld_addr = 16'h0099;
        settle();
        chk("R9 miss", ld_hit, 0);

        give_addr(2'd3, 16'h0030);
        give_data(2'd3, 32'h33);
        settle();
        chk("R6 retires later", commit_ok, 1);
        expect_write(16'h0030, 32'h33);
        commit_pulse();

        dispatch();
        give_addr(2'd0, 16'h0050);
        give_data(2'd0, 32'h55);
        settle();
        chk("R11 wb full blocks", commit_ok, 0);

        cw_ready = 1'b1;
        repeat (6) tick();
        settle();
        chk("R7 drained", cw_valid, 0);
        chk("R11 room again", commit_ok, 1);
        chk("R8 superseded not written", writes, 3);
        chk("R7 queue empty", exp_q.size(), 0);

        cw_ready = 1'b0;
        expect_write(16'h0050, 32'h55);
        commit_pulse();
        settle();
        chk("R10 next tag", disp_tag, 1);
        dispatch();
        dispatch();
        give_addr(2'd1, 16'h0060);
        give_data(2'd1, 32'h66);
        ld_addr = 16'h0060;
        settle();
        chk("R9 pre-flush hit", ld_hit, 1);
        flush = 1'b1; tick(); flush = 1'b0;
        settle();
        chk("R10 lookup gone", ld_hit, 0);
        chk("R10 commit_ok", commit_ok, 0);
        chk("R10 disp_ready", disp_ready, 1);
        chk("R10 disp_tag", disp_tag, 1);
        chk("R10 wb kept", cw_valid, 1);
        chk("R10 wb addr", cw_addr, 16'h0050);

        cw_ready = 1'b1;
        repeat (3) tick();
        settle();
        chk("R10 wb drained", writes, 4);
        chk("R7 final queue", exp_q.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule